// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the internal chip reset for a small controller. Four requests can start a reset: a power-on detect, a brown-out detect, the external active-low master-clear pin and a watchdog time-out. A set/reset latch holds the chip reset. Any request sets it, and it clears only when the start-up timing that applies to that request has run out.

Power-on and brown-out resets use two timers in a chain. The first is a 10-bit power-up timer clocked by the internal RC oscillator. The second is a 10-bit oscillator start-up timer clocked by the external oscillator. Master-clear and watchdog resets skip both timers. The oscillator start-up timer also runs after a wake-up from sleep when the oscillator mode is a crystal or low-frequency mode. During that time the phase clock is held but the chip reset stays low.

While reset is held, the block does four things:
- It forces every data-direction bit to input.
- It holds the phase clock.
- When the processor mode allows external execution, it overrides the external-bus strobes.
- It tells the watchdog when it may use the shared RC clock.

Four status bits (time-out, power-down, power-on flag, brown-out flag) record enough history for software to tell which reset occurred. The status bits and the software commands are synchronous to `rc_clk`. The four raw requests are treated as asynchronous and pass through two-flop synchronisers. There is no data stream, so every pin is a plain control or status pin.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_req` is high, `chip_rst` is 1 and the flags {to_flag, pd_flag, por_flag_n, bor_flag_n} read 4'b1101. After `por_req` falls, `chip_rst` stays high for 1024 `rc_clk` cycles plus 1024 `osc_clk` cycles plus synchroniser latency, within 2560 to 2595 `rc_clk` cycles at a 4 ns / 6 ns clock pair.
- R2: A brown-out request asserts `chip_rst` and clears `bor_flag_n` to 0. It sets `to_flag` and `pd_flag` to 1. After the request falls, it runs the same two-timer delay as R1.
- R3: While `mclr_n` is low, `chip_rst` is 1. When no power-up sequence is pending, `chip_rst` falls within 6 `rc_clk` cycles of `mclr_n` rising. All four flags are unchanged.
- R4: A rising watchdog request pulses `chip_rst` high for 1 to 3 `rc_clk` cycles without any timer. It clears `to_flag` and leaves `pd_flag` unchanged.
- R5: A rising `wake_evt` outside reset runs only the oscillator start-up timer when `osc_mode` is 2'b00 (low-frequency) or 2'b01 (crystal). It holds `phase_hold` for 1536 to 1560 `rc_clk` cycles while `chip_rst` stays 0. For modes 2'b10 and 2'b11 the wake-up causes no hold.
- R6: While `chip_rst` is 1, `ddr_force` and `phase_hold` are 1. If `ext_exec` is also 1, `bus_ale`=0, `bus_rd_n`=1 and `bus_wr_n`=1. In every other case the three bus pins pass the core values through.
- R7: `wdt_rc_en` is 0 while a power-on or brown-out reset sequence holds the chip. It is 1 otherwise.
- R8: Outside reset, `sleep_cmd` sets `pd_flag`=0 and `to_flag`=1, and `clrwdt_cmd` sets both to 1. While `chip_rst` is 1, both commands are ignored.
- R9: Only `sw_set_por` sets `por_flag_n`, and only `sw_set_bor` sets `bor_flag_n`. Master-clear and watchdog resets leave both flags unchanged.
- R10: A master-clear or watchdog reset during a power-up sequence restarts the full two-timer delay, counted from the moment that request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC oscillator clock |
| osc_clk | input | 1 | External oscillator clock |
| por_req | input | 1 | Power-on detect, active high, asynchronous |
| bor_req | input | 1 | Brown-out detect, active high |
| mclr_n | input | 1 | External master-clear, active low |
| wdt_req | input | 1 | Watchdog time-out request |
| wake_evt | input | 1 | Wake-up from sleep event |
| osc_mode | input | 2 | Oscillator mode code |
| ext_exec | input | 1 | Processor mode allows external execution |
| sleep_cmd | input | 1 | Core entered sleep (rc_clk strobe) |
| clrwdt_cmd | input | 1 | Core cleared watchdog (rc_clk strobe) |
| sw_set_por | input | 1 | Software sets power-on flag |
| sw_set_bor | input | 1 | Software sets brown-out flag |
| core_ale | input | 1 | Core address-latch-enable value |
| core_rd_n | input | 1 | Core output-enable strobe value |
| core_wr_n | input | 1 | Core write strobe value |
| chip_rst | output | 1 | Internal chip reset |
| ddr_force | output | 1 | Force all direction bits to input |
| phase_hold | output | 1 | Hold phase clock in first phase |
| bus_ale | output | 1 | Address-latch-enable pin value |
| bus_rd_n | output | 1 | Output-enable pin value |
| bus_wr_n | output | 1 | Write strobe pin value |
| wdt_rc_en | output | 1 | RC clock available to watchdog |
| to_flag | output | 1 | Time-out status |
| pd_flag | output | 1 | Power-down status |
| por_flag_n | output | 1 | Power-on flag, active low |
| bor_flag_n | output | 1 | Brown-out flag, active low |

## Verification
The hardest case to reach is a second request that arrives partway through a power-up sequence. The design must keep the power-up enable and restart both timers rather than release on the short master-clear path. The bench raises a brown-out, waits 500 cycles so that the power-up timer is mid-count, pulses master-clear, and then measures the full delay from that release. Wake-ups are also sent right after a timed reset, while the oscillator-side done signal may still be draining. The random phase mixes these cases with the other events under a fixed seed.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    SQ_RUN  = 3'd0,
    SQ_HOLD = 3'd1,
    SQ_PWRT = 3'd2,
    SQ_OST  = 3'd3,
    SQ_WAKE = 3'd4
  } seq_state_e;

  localparam int unsigned OSCM_W = 2;
  localparam logic [OSCM_W-1:0] OSCM_LOWF = 2'b00;
  localparam logic [OSCM_W-1:0] OSCM_XTAL = 2'b01;
  localparam logic [OSCM_W-1:0] OSCM_EXT  = 2'b10;
  localparam logic [OSCM_W-1:0] OSCM_RC   = 2'b11;

  function automatic logic wake_needs_ost(logic [OSCM_W-1:0] m);
    return (m == OSCM_LOWF) || (m == OSCM_XTAL);
  endfunction
endpackage

// File: rtl/rst_sync_n.sv
module rst_sync_n #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q <= '0;
    else      q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/startup_cnt.sv
module startup_cnt #(
  parameter int TMR_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic done
);
  localparam logic [TMR_BITS-1:0] CNT_LAST = {TMR_BITS{1'b1}};

  logic [TMR_BITS-1:0] cnt_q;
  logic                done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (run && !done_q) begin
      if (cnt_q == CNT_LAST) done_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int TMR_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bor_s,
  input  logic              mclr_s,
  input  logic              wdt_s,
  input  logic              wake_s,
  input  logic [OSCM_W-1:0] osc_mode,
  input  logic              ost_done_s,
  output logic              chip_rst,
  output logic              ost_req,
  output logic              wake_hold,
  output logic              pwrt_busy,
  output logic              pwrt_en,
  output logic              wdt_evt,
  output logic              bor_evt
);
  seq_state_e state_q, state_d;
  logic wdt_d, bor_d, wake_d;
  logic latch_q, pwrt_en_q, wake_pend_q;
  logic level_src, set_req, timeout, wake_rise, pwrt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_d  <= 1'b0;
      bor_d  <= 1'b0;
      wake_d <= 1'b0;
    end else begin
      wdt_d  <= wdt_s;
      bor_d  <= bor_s;
      wake_d <= wake_s;
    end
  end

  assign wdt_evt   = wdt_s & ~wdt_d;
  assign bor_evt   = bor_s & ~bor_d;
  assign wake_rise = wake_s & ~wake_d;
  assign level_src = bor_s | mclr_s;
  assign set_req   = level_src | wdt_evt;

  startup_cnt #(.TMR_BITS(TMR_BITS)) u_pwrt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == SQ_PWRT),
    .clr  (state_q != SQ_PWRT),
    .done (pwrt_done)
  );

  always_comb begin
    state_d = state_q;
    timeout = 1'b0;
    if (set_req) begin
      state_d = SQ_HOLD;
    end else begin
      case (state_q)
        SQ_HOLD: begin
          if (pwrt_en_q) state_d = SQ_PWRT;
          else begin
            state_d = SQ_RUN;
            timeout = 1'b1;
          end
        end
        SQ_PWRT: if (pwrt_done && !ost_done_s) state_d = SQ_OST;
        SQ_OST: begin
          if (ost_done_s) begin
            state_d = SQ_RUN;
            timeout = 1'b1;
          end
        end
        SQ_RUN:  if (wake_pend_q && !ost_done_s) state_d = SQ_WAKE;
        SQ_WAKE: if (ost_done_s) state_d = SQ_RUN;
        default: state_d = SQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_HOLD;
      latch_q     <= 1'b1;
      pwrt_en_q   <= 1'b1;
      wake_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_req)      latch_q <= 1'b1;
      else if (timeout) latch_q <= 1'b0;
      if (bor_s)        pwrt_en_q <= 1'b1;
      else if (timeout) pwrt_en_q <= 1'b0;
      if (set_req || state_q != SQ_RUN || state_d == SQ_WAKE)
        wake_pend_q <= 1'b0;
      else if (wake_rise && wake_needs_ost(osc_mode))
        wake_pend_q <= 1'b1;
    end
  end

  assign chip_rst  = latch_q;
  assign ost_req   = (state_q == SQ_OST) || (state_q == SQ_WAKE);
  assign wake_hold = (state_q == SQ_WAKE);
  assign pwrt_busy = latch_q & pwrt_en_q;
  assign pwrt_en   = pwrt_en_q;
endmodule

// File: rtl/rst_status_bits.sv
module rst_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ok,
  input  logic bor_evt,
  input  logic wdt_evt,
  input  logic sleep_cmd,
  input  logic clrwdt_cmd,
  input  logic sw_set_por,
  input  logic sw_set_bor,
  output logic to_flag,
  output logic pd_flag,
  output logic por_flag_n,
  output logic bor_flag_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag    <= 1'b1;
      pd_flag    <= 1'b1;
      por_flag_n <= 1'b0;
      bor_flag_n <= 1'b1;
    end else begin
      if (bor_evt) begin
        to_flag    <= 1'b1;
        pd_flag    <= 1'b1;
        bor_flag_n <= 1'b0;
      end else if (wdt_evt) begin
        to_flag <= 1'b0;
      end else if (cmd_ok && clrwdt_cmd) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b1;
      end else if (cmd_ok && sleep_cmd) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b0;
      end
      if (cmd_ok && sw_set_por) por_flag_n <= 1'b1;
      if (cmd_ok && sw_set_bor && !bor_evt) bor_flag_n <= 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int TMR_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rc_clk,
  input  logic              osc_clk,
  input  logic              por_req,
  input  logic              bor_req,
  input  logic              mclr_n,
  input  logic              wdt_req,
  input  logic              wake_evt,
  input  logic [OSCM_W-1:0] osc_mode,
  input  logic              ext_exec,
  input  logic              sleep_cmd,
  input  logic              clrwdt_cmd,
  input  logic              sw_set_por,
  input  logic              sw_set_bor,
  input  logic              core_ale,
  input  logic              core_rd_n,
  input  logic              core_wr_n,
  output logic              chip_rst,
  output logic              ddr_force,
  output logic              phase_hold,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              wdt_rc_en,
  output logic              to_flag,
  output logic              pd_flag,
  output logic              por_flag_n,
  output logic              bor_flag_n
);
  localparam int REQ_W = 4;

  logic rst_rc_n, rst_osc_n;
  logic [REQ_W-1:0] req_s;
  logic bor_s, mclr_s, wdt_s, wake_s;
  logic ost_req, ost_req_o, ost_done_o, ost_done_s;
  logic wake_hold, pwrt_busy, pwrt_en_q, wdt_evt, bor_evt;
  logic bus_force;

  rst_sync_n #(.STAGES(SYNC_STAGES)) u_rst_rc (
    .clk(rc_clk), .arst(por_req), .rst_n(rst_rc_n)
  );
  rst_sync_n #(.STAGES(SYNC_STAGES)) u_rst_osc (
    .clk(osc_clk), .arst(por_req), .rst_n(rst_osc_n)
  );

  bit_sync #(.W(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_req_sync (
    .clk  (rc_clk),
    .rst_n(rst_rc_n),
    .d    ({bor_req, ~mclr_n, wdt_req, wake_evt}),
    .q    (req_s)
  );
  assign {bor_s, mclr_s, wdt_s, wake_s} = req_s;

  rst_seq_fsm #(.TMR_BITS(TMR_BITS)) u_fsm (
    .clk       (rc_clk),
    .rst_n     (rst_rc_n),
    .bor_s     (bor_s),
    .mclr_s    (mclr_s),
    .wdt_s     (wdt_s),
    .wake_s    (wake_s),
    .osc_mode  (osc_mode),
    .ost_done_s(ost_done_s),
    .chip_rst  (chip_rst),
    .ost_req   (ost_req),
    .wake_hold (wake_hold),
    .pwrt_busy (pwrt_busy),
    .pwrt_en   (pwrt_en_q),
    .wdt_evt   (wdt_evt),
    .bor_evt   (bor_evt)
  );

  bit_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_to_osc (
    .clk(osc_clk), .rst_n(rst_osc_n), .d(ost_req), .q(ost_req_o)
  );

  startup_cnt #(.TMR_BITS(TMR_BITS)) u_ost (
    .clk  (osc_clk),
    .rst_n(rst_osc_n),
    .run  (ost_req_o),
    .clr  (~ost_req_o),
    .done (ost_done_o)
  );

  bit_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_to_rc (
    .clk(rc_clk), .rst_n(rst_rc_n), .d(ost_done_o), .q(ost_done_s)
  );

  rst_status_bits u_status (
    .clk       (rc_clk),
    .rst_n     (rst_rc_n),
    .cmd_ok    (~chip_rst),
    .bor_evt   (bor_evt),
    .wdt_evt   (wdt_evt),
    .sleep_cmd (sleep_cmd),
    .clrwdt_cmd(clrwdt_cmd),
    .sw_set_por(sw_set_por),
    .sw_set_bor(sw_set_bor),
    .to_flag   (to_flag),
    .pd_flag   (pd_flag),
    .por_flag_n(por_flag_n),
    .bor_flag_n(bor_flag_n)
  );

  assign bus_force  = chip_rst & ext_exec;
  assign ddr_force  = chip_rst;
  assign phase_hold = chip_rst | wake_hold;
  assign bus_ale    = bus_force ? 1'b0 : core_ale;
  assign bus_rd_n   = bus_force ? 1'b1 : core_rd_n;
  assign bus_wr_n   = bus_force ? 1'b1 : core_wr_n;
  assign wdt_rc_en  = ~pwrt_busy;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic rc_clk,
  input logic rst_rc_n,
  input logic mclr_n,
  input logic chip_rst,
  input logic ext_exec,
  input logic bus_ale,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic wdt_evt,
  input logic to_flag,
  input logic por_flag_n,
  input logic sw_set_por,
  input logic pwrt_en_q,
  input logic ost_done_s
);
  p_mclr_holds_r3: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    ($past(!mclr_n, 2) && $past(!mclr_n) && !mclr_n) |=> chip_rst);

  p_bus_forced_r6: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    (chip_rst && ext_exec) |-> (!bus_ale && bus_rd_n && bus_wr_n));

  p_release_after_ost_r1: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    ($fell(chip_rst) && $past(pwrt_en_q)) |-> $past(ost_done_s));

  p_wdt_clears_to_r4: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    $past(wdt_evt) |-> !to_flag);

  p_por_flag_sw_only_r9: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    $rose(por_flag_n) |-> $past(sw_set_por));
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .rc_clk    (rc_clk),
  .rst_rc_n  (rst_rc_n),
  .mclr_n    (mclr_n),
  .chip_rst  (chip_rst),
  .ext_exec  (ext_exec),
  .bus_ale   (bus_ale),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .wdt_evt   (wdt_evt),
  .to_flag   (to_flag),
  .por_flag_n(por_flag_n),
  .sw_set_por(sw_set_por),
  .pwrt_en_q (pwrt_en_q),
  .ost_done_s(ost_done_s)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  logic rc_clk = 1'b0;
  logic osc_clk = 1'b0;
  always #2 rc_clk = ~rc_clk;
  always #3 osc_clk = ~osc_clk;

  logic por_req = 1'b1, bor_req = 1'b0, mclr_n = 1'b1, wdt_req = 1'b0, wake_evt = 1'b0;
  logic [1:0] osc_mode = 2'b01;
  logic ext_exec = 1'b0, sleep_cmd = 1'b0, clrwdt_cmd = 1'b0;
  logic sw_set_por = 1'b0, sw_set_bor = 1'b0;
  logic core_ale = 1'b1, core_rd_n = 1'b0, core_wr_n = 1'b0;
  logic chip_rst, ddr_force, phase_hold, bus_ale, bus_rd_n, bus_wr_n, wdt_rc_en;
  logic to_flag, pd_flag, por_flag_n, bor_flag_n;

  rst_seq_ctrl dut_i (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rst_hi_cnt = 0;
  logic m_to, m_pd, m_por_n, m_bor_n;

  always @(negedge rc_clk) begin
    cyc <= cyc + 1;
    if (chip_rst === 1'b1) rst_hi_cnt <= rst_hi_cnt + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic int exp_flags(logic t, logic p, logic pn, logic bn);
    return int'({t, p, pn, bn});
  endfunction

  function automatic int exp_bus(logic rst, logic ext, logic a, logic r, logic w);
    if (rst && ext) return 3'b011;
    return int'({a, r, w});
  endfunction

  function automatic int act_flags();
    return int'({to_flag, pd_flag, por_flag_n, bor_flag_n});
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (chip_rst && n < 6000) begin
      @(negedge rc_clk);
      n++;
    end
  endtask

  task automatic chk_flags(input string tag);
    chk(tag, act_flags(), exp_flags(m_to, m_pd, m_por_n, m_bor_n));
  endtask

  task automatic pulse(ref logic sig, input int n);
    sig = 1'b1;
    tick(n);
    sig = 1'b0;
  endtask

  task automatic do_wake(input logic [1:0] mode, input string tag);
    int n, base;
    osc_mode = mode;
    base = rst_hi_cnt;
    pulse(wake_evt, 3);
    n = 0;
    while (!phase_hold && n < 12) begin
      tick(1);
      n++;
    end
    n = 0;
    while (phase_hold && n < 4000) begin
      tick(1);
      n++;
    end
    if (mode == 2'b00 || mode == 2'b01) chk_rng({tag, " R5 wake hold"}, n, 1536, 1560);
    else chk({tag, " R5 no wake hold"}, n, 0);
    chk({tag, " R5 no chip_rst on wake"}, rst_hi_cnt - base, 0);
    tick(10);
  endtask

  task automatic do_bor(input string tag);
    int n;
    bor_req = 1'b1;
    tick(20);
    m_to = 1'b1; m_pd = 1'b1; m_bor_n = 1'b0;
    chk({tag, " R2 rst during bor"}, int'(chip_rst), 1);
    chk({tag, " R7 wdt rc gated"}, int'(wdt_rc_en), 0);
    chk_flags({tag, " R2 flags"});
    bor_req = 1'b0;
    wait_low(n);
    chk_rng({tag, " R2 bor delay"}, n, 2560, 2595);
    tick(10);
  endtask

  initial begin
    int n, base, op, bor_cnt;
    void'($urandom(32'd24681));
    m_to = 1'b1; m_pd = 1'b1; m_por_n = 1'b0; m_bor_n = 1'b1;
    tick(6);
    chk("R1 chip_rst in por", int'(chip_rst), 1);
    chk("R6 ddr_force in por", int'(ddr_force), 1);
    chk("R6 phase_hold in por", int'(phase_hold), 1);
    chk("R7 wdt rc gated in por", int'(wdt_rc_en), 0);
    chk_flags("R1 flags in por");
    chk("R6 bus pass when not ext", int'({bus_ale, bus_rd_n, bus_wr_n}),
        exp_bus(1'b1, 1'b0, core_ale, core_rd_n, core_wr_n));
    ext_exec = 1'b1;
    tick(1);
    chk("R6 bus forced", int'({bus_ale, bus_rd_n, bus_wr_n}),
        exp_bus(1'b1, 1'b1, core_ale, core_rd_n, core_wr_n));
    por_req = 1'b0;
    tick(1);
    wait_low(n);
    chk_rng("R1 por release delay", n + 1, 2560, 2595);
    chk("R7 wdt rc free after por", int'(wdt_rc_en), 1);
    chk("R6 phase_hold released", int'(phase_hold), 0);
    chk("R6 bus pass after rst", int'({bus_ale, bus_rd_n, bus_wr_n}),
        exp_bus(1'b0, 1'b1, core_ale, core_rd_n, core_wr_n));
    chk_flags("R1 flags after por");

    pulse(sw_set_por, 1);
    tick(2);
    m_por_n = 1'b1;
    chk_flags("R9 sw sets por flag");

    bor_req = 1'b1;
    tick(20);
    m_to = 1'b1; m_pd = 1'b1; m_bor_n = 1'b0;
    chk_flags("R2 flags on bor");
    bor_req = 1'b0;
    tick(500);
    chk("R10 still in pwrt", int'(chip_rst), 1);
    pulse(mclr_n, 0);
    mclr_n = 1'b0;
    tick(10);
    mclr_n = 1'b1;
    wait_low(n);
    chk_rng("R10 full restart after mclr", n, 2560, 2595);
    chk_flags("R9 mclr keeps flags");

    pulse(sleep_cmd, 1);
    tick(2);
    m_pd = 1'b0; m_to = 1'b1;
    chk_flags("R8 sleep clears pd");

    mclr_n = 1'b0;
    tick(5);
    chk("R3 rst while mclr low", int'(chip_rst), 1);
    pulse(clrwdt_cmd, 1);
    tick(3);
    chk_flags("R8 clrwdt ignored in rst");
    mclr_n = 1'b1;
    wait_low(n);
    chk_rng("R3 mclr fast release", n, 0, 6);
    chk_flags("R3 mclr flags unchanged");

    base = rst_hi_cnt;
    pulse(wdt_req, 3);
    tick(10);
    m_to = 1'b0;
    chk_rng("R4 wdt rst pulse", rst_hi_cnt - base, 1, 3);
    chk_flags("R4 wdt clears to");

    do_wake(2'b01, "dir xtal");
    do_wake(2'b10, "dir ext");

    bor_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      op = $urandom_range(0, 7);
      ext_exec = 1'($urandom_range(0, 1));
      core_ale = 1'($urandom_range(0, 1));
      core_rd_n = 1'($urandom_range(0, 1));
      core_wr_n = 1'($urandom_range(0, 1));
      case (op)
        0: begin
          mclr_n = 1'b0;
          tick($urandom_range(3, 20));
          chk("R3 rnd rst with mclr", int'(chip_rst), 1);
          chk("R6 rnd bus in rst", int'({bus_ale, bus_rd_n, bus_wr_n}),
              exp_bus(1'b1, ext_exec, core_ale, core_rd_n, core_wr_n));
          mclr_n = 1'b1;
          wait_low(n);
          chk_rng("R3 rnd release", n, 0, 6);
        end
        1: begin
          base = rst_hi_cnt;
          pulse(wdt_req, 3);
          tick(8);
          m_to = 1'b0;
          chk_rng("R4 rnd wdt pulse", rst_hi_cnt - base, 1, 3);
        end
        2: begin pulse(sleep_cmd, 1); m_to = 1'b1; m_pd = 1'b0; end
        3: begin pulse(clrwdt_cmd, 1); m_to = 1'b1; m_pd = 1'b1; end
        4: begin pulse(sw_set_por, 1); m_por_n = 1'b1; end
        5: begin pulse(sw_set_bor, 1); m_bor_n = 1'b1; end
        6: do_wake(2'($urandom_range(0, 3)), "rnd");
        default: begin
          if (bor_cnt < 3) begin
            do_bor("rnd");
            bor_cnt++;
          end
        end
      endcase
      tick(3);
      chk_flags("R8 R9 rnd flags");
      chk("R6 rnd bus outside rst", int'({bus_ale, bus_rd_n, bus_wr_n}),
          exp_bus(1'b0, ext_exec, core_ale, core_rd_n, core_wr_n));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule